// File: doc/BRIEF.md
# Interrupt and Overflow Controller

This block collects a set of single-bit event conditions coming from a converter core and turns them into one host interrupt line. Each condition first crosses into the block's clock domain through a two-flop synchronizer. A per-source sensitivity code then decides whether the status bit follows the live condition or latches a chosen transition. A per-source mask decides whether that status bit may raise the interrupt. The host reads status through a small register port, and the read releases latched edge events.

The interrupt pin has two output modes, selected by one configuration bit. In one mode it is a push-pull output that is high when active. In the other it is an open-drain output that pulls low when active and otherwise floats, so it can share a wired-OR line. The block drives the pin through a value output and a drive-enable output, and the board pull-up is outside it. A second open-drain pin reports overflow or underflow directly from the synchronized conditions. This pin ignores both masks and sensitivity.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask register reads 0xFF (all sources masked), the configuration register reads 0x00 (open-drain mode), both sensitivity registers read 0x00 (all level), and the interrupt pin is released (`irq_pad_oe_o`=0, `irq_pad_o`=0).
- R2: A status bit whose mask bit is 1 never makes the interrupt active, whatever its value.
- R3: Each source i has a 2-bit sensitivity code at bits [2i+1:2i] of the concatenated sensitivity registers. The codes are 00 = level, 01 = rising edge, 10 = falling edge, 11 = level. An edge-coded status bit sets on its selected transition of the synchronized input, ignores the other transition, and stays set until it is cleared.
- R4: A level-coded status bit equals the synchronized input. It is not latched, and reading status does not clear it.
- R5: A read of status at address 0x0D returns the current status and clears every edge-coded bit. An edge detected on the same clock as that read leaves its bit set.
- R6: The interrupt is active exactly when some status bit is 1 and its mask bit (address 0x0E, bit i for source i, 1 = masked) is 0.
- R7: Configuration bit 0 (address 0x0C) picks the interrupt mode. With 1 the pin is push-pull: `irq_pad_oe_o`=1 and `irq_pad_o` equals the active state. With 0 it is open-drain: `irq_pad_o`=0 and `irq_pad_oe_o` equals the active state.
- R8: `ovf_pad_oe_o` (pull low when 1) is the OR of the synchronized source 0 (overflow) and source 1 (underflow) conditions, independent of mask and sensitivity settings.
- R9: A source change present at clock edge k shows in status and in `ovf_pad_oe_o` after edge k+2, and not before.
- R10: Writes to status (0x0D) change nothing. Configuration bits 7:1 are not stored and read as 0.
- R11: Register map: 0x0C configuration, 0x0D status, 0x0E mask, 0x10 sensitivity for sources 0-3, 0x11 sensitivity for sources 4-7. Any other address reads 0x00. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw event conditions (bit 0 overflow, bit 1 underflow) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on status only) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_pad_o | output | 1 | Interrupt pin value |
| irq_pad_oe_o | output | 1 | Interrupt pin drive enable |
| ovf_pad_oe_o | output | 1 | Overflow pin pull-low enable |

## Verification
The hardest case to reach from the ports is a new edge that lands on the same clock as the clearing status read. The input has to be changed exactly two clocks ahead of the read strobe so that the synchronizer delivers the edge on the read edge. The stimulus places a rising edge at that offset and then reads twice: first to see the bit survive, then to see it clear. A long random phase mixes inputs, mask, sensitivity and mode writes with reads, and a cycle-accurate model in the bench follows every one of them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SENSE_LEVEL     = 2'b00,
        SENSE_RISE      = 2'b01,
        SENSE_FALL      = 2'b10,
        SENSE_LEVEL_ALT = 2'b11
    } sense_e;

    localparam int unsigned CFG_ADDR    = 12;
    localparam int unsigned STATUS_ADDR = 13;
    localparam int unsigned MASK_ADDR   = 14;
    localparam int unsigned SENSE_ADDR  = 16;

    function automatic logic is_edge_code(logic [1:0] code);
        return (code == SENSE_RISE) || (code == SENSE_FALL);
    endfunction

    // Next value of one status bit from its sensitivity code.
    function automatic logic bit_next(logic [1:0] code, logic cur, logic prv,
                                      logic held, logic clr);
        if (code == SENSE_RISE) begin
            return (cur & ~prv) | (held & ~clr);
        end else if (code == SENSE_FALL) begin
            return (~cur & prv) | (held & ~clr);
        end else begin
            return cur;
        end
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.last = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
    assign prev_o = st_q.last;

endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_SRC-1:0]     cur_i,
    input  logic [NUM_SRC-1:0]     prev_i,
    input  logic [2*NUM_SRC-1:0]   sense_i,
    input  logic                   clr_i,
    output logic [NUM_SRC-1:0]     status_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } status_t;

    status_t            st_d, st_q;
    logic [NUM_SRC-1:0] next_bits;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        assign next_bits[i] = bit_next(sense_i[2*i +: 2], cur_i[i], prev_i[i],
                                       st_q.bits[i], clr_i);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = next_bits;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_SRC-1:0]   status_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NUM_SRC-1:0]   mask_o,
    output logic [2*NUM_SRC-1:0] sense_o,
    output logic                 push_pull_o,
    output logic                 status_rd_o
);

    localparam int SENS_W    = 2 * NUM_SRC;
    localparam int SENS_REGS = (SENS_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W     = SENS_REGS * DATA_W;

    typedef struct packed {
        logic               push_pull;
        logic [NUM_SRC-1:0] mask;
        logic [PAD_W-1:0]   sense;
    } cfg_t;

    cfg_t                              st_d, st_q;
    logic                              hit_cfg, hit_mask, hit_status;
    logic [SENS_REGS-1:0]              sens_hit;
    logic [SENS_REGS-1:0][DATA_W-1:0]  sens_words;

    assign hit_cfg    = (addr_i == ADDR_W'(CFG_ADDR));
    assign hit_mask   = (addr_i == ADDR_W'(MASK_ADDR));
    assign hit_status = (addr_i == ADDR_W'(STATUS_ADDR));
    assign sens_words = st_q.sense;

    for (genvar k = 0; k < SENS_REGS; k++) begin : g_sens
        assign sens_hit[k] = (addr_i == ADDR_W'(SENSE_ADDR + k));
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (hit_cfg) begin
                st_d.push_pull = wdata_i[0];
            end
            if (hit_mask) begin
                st_d.mask = wdata_i[NUM_SRC-1:0];
            end
            for (int k = 0; k < SENS_REGS; k++) begin
                if (sens_hit[k]) begin
                    st_d.sense[k*DATA_W +: DATA_W] = wdata_i;
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_cfg) begin
            rdata_o = DATA_W'(st_q.push_pull);
        end else if (hit_status) begin
            rdata_o = DATA_W'(status_i);
        end else if (hit_mask) begin
            rdata_o = DATA_W'(st_q.mask);
        end else begin
            for (int k = 0; k < SENS_REGS; k++) begin
                if (sens_hit[k]) begin
                    rdata_o = sens_words[k];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{push_pull: 1'b0, mask: '1, sense: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o      = st_q.mask;
    assign sense_o     = st_q.sense[SENS_W-1:0];
    assign push_pull_o = st_q.push_pull;
    assign status_rd_o = rd_en_i && hit_status;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int OVF_IDX = 0,
    parameter int UNF_IDX = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_pad_o,
    output logic               irq_pad_oe_o,
    output logic               ovf_pad_oe_o
);

    typedef struct packed {
        logic ovf;
    } pin_t;

    logic [NUM_SRC-1:0]   sync_w, prev_w, status_w, mask_w;
    logic [2*NUM_SRC-1:0] sense_w;
    logic                 push_pull_w, clr_w, irq_act_w;
    pin_t                 st_d, st_q;

    irqc_sync #(.W(NUM_SRC), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (src_i),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cur_i    (sync_w),
        .prev_i   (prev_w),
        .sense_i  (sense_w),
        .clr_i    (clr_w),
        .status_o (status_w)
    );

    irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .status_i    (status_w),
        .rdata_o     (rdata_o),
        .mask_o      (mask_w),
        .sense_o     (sense_w),
        .push_pull_o (push_pull_w),
        .status_rd_o (clr_w)
    );

    // Overflow pin: straight from synchronized conditions, no mask.
    always_comb begin
        st_d     = st_q;
        st_d.ovf = sync_w[OVF_IDX] | sync_w[UNF_IDX];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_act_w    = |(status_w & ~mask_w);
    assign irq_pad_o    = push_pull_w & irq_act_w;
    assign irq_pad_oe_o = push_pull_w | irq_act_w;
    assign ovf_pad_oe_o = st_q.ovf;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 8,
    parameter int OVF_IDX = 0,
    parameter int UNF_IDX = 1
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NUM_SRC-1:0]     src_i,
    input logic                   rd_en_i,
    input logic [ADDR_W-1:0]      addr_i,
    input logic [NUM_SRC-1:0]     status_i,
    input logic [NUM_SRC-1:0]     mask_i,
    input logic [2*NUM_SRC-1:0]   sense_i,
    input logic                   push_pull_i,
    input logic                   irq_pad_o,
    input logic                   irq_pad_oe_o,
    input logic                   ovf_pad_oe_o
);

    logic [1:0] warm_q;
    logic       status_read;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assign status_read = rd_en_i && (addr_i == ADDR_W'(STATUS_ADDR));

    // R2: all-masked status leaves the pin idle for its mode.
    a_r2_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_i & ~mask_i) == '0) |-> (!irq_pad_o && (irq_pad_oe_o == push_pull_i)));

    // R6: an unmasked set bit activates the pin.
    a_r6_unmasked_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_i & ~mask_i) != '0) |-> (push_pull_i ? irq_pad_o : irq_pad_oe_o));

    // R7: open-drain mode never drives high.
    a_r7_od_no_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !push_pull_i |-> !irq_pad_o);

    // R7: push-pull mode always drives.
    a_r7_pp_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_pull_i |-> irq_pad_oe_o);

    // R8 and R9: overflow pin follows raw conditions three samples back.
    a_r8_ovf_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q == 2'd3) |-> (ovf_pad_oe_o == $past(src_i[OVF_IDX] | src_i[UNF_IDX], 3)));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
        // R3: a latched edge bit survives until a status read.
        a_r3_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (is_edge_code(sense_i[2*i +: 2]) && status_i[i] && !status_read)
            |=> status_i[i]);
    end

endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .OVF_IDX (OVF_IDX),
    .UNF_IDX (UNF_IDX)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_i        (src_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .status_i     (status_w),
    .mask_i       (mask_w),
    .sense_i      (sense_w),
    .push_pull_i  (push_pull_w),
    .irq_pad_o    (irq_pad_o),
    .irq_pad_oe_o (irq_pad_oe_o),
    .ovf_pad_oe_o (ovf_pad_oe_o)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_pad, irq_oe, ovf_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqc_top dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_i        (src),
        .wr_en_i      (wr_en),
        .rd_en_i      (rd_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .irq_pad_o    (irq_pad),
        .irq_pad_oe_o (irq_oe),
        .ovf_pad_oe_o (ovf_oe)
    );

    // Board-level view of the pins with pull-ups.
    wire irq_line = irq_oe ? irq_pad : 1'b1;
    wire ovf_line = ovf_oe ? 1'b0 : 1'b1;

    // ---------------- reference model ----------------
    logic [7:0]  m_status, m_mask, m_s2, m_s3, m_nst;
    logic [15:0] m_sens;
    logic        m_cfg, m_ovf, m_clr;
    logic [7:0]  hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 8'h00;
            m_mask   = 8'hFF;
            m_cfg    = 1'b0;
            m_sens   = 16'h0000;
            m_ovf    = 1'b0;
            hist     = '{8'h00, 8'h00, 8'h00};
        end else begin
            m_s2  = hist[1];
            m_s3  = hist[2];
            m_clr = rd_en && (addr == 8'h0D);
            for (int i = 0; i < 8; i++) begin
                case (m_sens[2*i +: 2])
                    2'b01:   m_nst[i] = (m_s2[i] && !m_s3[i]) || (m_status[i] && !m_clr);
                    2'b10:   m_nst[i] = (!m_s2[i] && m_s3[i]) || (m_status[i] && !m_clr);
                    default: m_nst[i] = m_s2[i];
                endcase
            end
            m_status = m_nst;
            m_ovf    = m_s2[0] | m_s2[1];
            hist.push_front(src);
            void'(hist.pop_back());
            if (wr_en) begin
                case (addr)
                    8'h0C:   m_cfg = wdata[0];
                    8'h0E:   m_mask = wdata;
                    8'h10:   m_sens[7:0] = wdata;
                    8'h11:   m_sens[15:8] = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_rdata(logic [7:0] a);
        case (a)
            8'h0C:   return {7'b0, m_cfg};
            8'h0D:   return m_status;
            8'h0E:   return m_mask;
            8'h10:   return m_sens[7:0];
            8'h11:   return m_sens[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic act;
            act = |(m_status & ~m_mask);
            chk("R11 rdata", rdata, m_rdata(addr));
            chk("R7 irq_pad", {7'b0, irq_pad}, {7'b0, m_cfg & act});
            chk("R6 irq_oe", {7'b0, irq_oe}, {7'b0, m_cfg | act});
            chk("R8 ovf_oe", {7'b0, ovf_oe}, {7'b0, m_ovf});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        step(1);
        rd_en = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd_chk(8'h0E, 8'hFF, "R1 mask reset");
        rd_chk(8'h0C, 8'h00, "R1 cfg reset");
        rd_chk(8'h10, 8'h00, "R1 sense low reset");
        rd_chk(8'h11, 8'h00, "R1 sense high reset");
        chk("R1 irq released", {6'b0, irq_oe, irq_pad}, 8'h00);

        // R2 masked level source stays quiet
        src = 8'h04;
        step(3);
        chk("R2 masked irq_oe", {7'b0, irq_oe}, 8'h00);
        rd_chk(8'h0D, 8'h04, "R4 level status");

        // R6 unmask, open-drain pulls low
        wr(8'h0E, 8'hFB);
        chk("R6 unmasked irq_oe", {7'b0, irq_oe}, 8'h01);
        chk("R7 open-drain line low", {7'b0, irq_line}, 8'h00);
        rd_chk(8'h0D, 8'h04, "R4 level not cleared by read");
        src = 8'h00;
        step(3);
        chk("R4 level follows input", {7'b0, irq_oe}, 8'h00);

        // R3 rising edge on source 3
        wr(8'h10, 8'h40);
        wr(8'h0E, 8'hF3);
        src = 8'h08;
        step(3);
        chk("R3 rising sets irq", {7'b0, irq_oe}, 8'h01);
        rd_chk(8'h0D, 8'h08, "R3 rising latched");
        rd_chk(8'h0D, 8'h00, "R5 read clears edge bit");
        src = 8'h00;
        step(3);
        rd_chk(8'h0D, 8'h00, "R3 rising ignores fall");

        // R3 falling edge on source 4
        wr(8'h11, 8'h02);
        src = 8'h10;
        step(3);
        rd_chk(8'h0D, 8'h00, "R3 falling ignores rise");
        src = 8'h00;
        step(3);
        rd_chk(8'h0D, 8'h10, "R3 falling latched");

        // R5 edge on the same clock as the clearing read
        wr(8'h11, 8'h06);
        src = 8'h20;
        step(2);
        rd_chk(8'h0D, 8'h00, "R5 before collision");
        rd_chk(8'h0D, 8'h20, "R5 new edge wins over clear");
        rd_chk(8'h0D, 8'h00, "R5 cleared afterwards");

        // R7 push-pull mode
        wr(8'h0E, 8'hFB);
        wr(8'h0C, 8'h01);
        src = 8'h04;
        step(3);
        chk("R7 push-pull active", {6'b0, irq_oe, irq_pad}, 8'h03);
        src = 8'h00;
        step(3);
        chk("R7 push-pull idle", {6'b0, irq_oe, irq_pad}, 8'h02);
        wr(8'h0C, 8'hFF);
        rd_chk(8'h0C, 8'h01, "R10 cfg upper bits dropped");
        wr(8'h0D, 8'hFF);
        rd_chk(8'h0D, 8'h00, "R10 status write ignored");

        // R8 and R9 overflow pin
        wr(8'h0E, 8'hFF);
        src = 8'h01;
        step(2);
        chk("R9 ovf not yet", {7'b0, ovf_oe}, 8'h00);
        step(1);
        chk("R9 ovf after two syncs", {7'b0, ovf_line}, 8'h00);
        chk("R8 ovf ignores mask", {7'b0, ovf_oe}, 8'h01);
        chk("R2 masked push-pull low", {7'b0, irq_pad}, 8'h00);
        src = 8'h02;
        step(3);
        chk("R8 underflow drives ovf", {7'b0, ovf_oe}, 8'h01);
        src = 8'h00;
        step(3);
        chk("R8 ovf released", {7'b0, ovf_oe}, 8'h00);

        // R11 map
        rd_chk(8'h00, 8'h00, "R11 unmapped reads zero");
        rd_chk(8'h0F, 8'h00, "R11 hole reads zero");
        rd_chk(8'h10, 8'h40, "R11 sense low readback");
        rd_chk(8'h11, 8'h06, "R11 sense high readback");

        // Random mix, compared every clock against the model
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 3) == 0) src = 8'($urandom);
            wr_en = (($urandom % 6) == 0);
            rd_en = (($urandom % 3) == 0);
            case ($urandom % 6)
                0: addr = 8'h0C;
                1: addr = 8'h0D;
                2: addr = 8'h0E;
                3: addr = 8'h10;
                4: addr = 8'h11;
                default: addr = 8'h0D;
            endcase
            wdata = 8'($urandom);
            step(1);
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
        step(2);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule